// File: doc/BRIEF.md
# AC-link output frame formatter

This block is the controller-side transmitter of a serial audio codec link. It runs on the link's bit clock. It produces the frame marker (`ac_sync`) and the serial output stream (`ac_sdout`). Every frame is 256 bit clocks long. A 16-bit tag slot comes first, followed by twelve 20-bit data slots. All fields are sent MSB first.

Once per frame the block accepts one frame request through a valid/ready handshake. The request holds a command address, command data, a left and a right playback sample, an enable for each of these four items, and the 2-bit identifier of the codec the frame is meant for. The block builds the tag from the enables and the identifier. It then places the two samples in the slot pair that the identifier selects. Slots 1 and 2 carry the command address and command data. Every slot that has no content is sent as zero.

Back-pressure rules: `req_ready` is high for exactly one bit clock per frame, in the last bit period of the current frame. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. The producer must hold `req_valid` and its fields until that edge. Request fields may change freely while `req_ready` is low. If `req_valid` is low when `req_ready` is high, the next frame goes out empty (all zeros).

Top module: `aclink_frame_tx`

## Requirements
- R1: After reset, `ac_sync` and `ac_sdout` are 0 and `req_ready` is 1. Frames then follow back to back, each 256 bit clocks long. `req_ready` is high for one clock in the last bit period of each frame and low otherwise.
- R2: `ac_sync` goes high in the clock after an edge on which `req_ready` was high. It stays high for 16 clocks and is low for the remaining 240 clocks of the frame.
- R3: Tag bit 15 appears on `ac_sdout` in the clock after `ac_sync` rises. One bit is sent per clock after that, MSB first: tag bits 15 down to 0, then slot 1 bits 19 down to 0, and so on through slot 12.
- R4: Tag bit 15 (valid frame) is 1 exactly when at least one of the four request enables of the accepted request is 1.
- R5: Tag bit 14−(s−1) is the valid flag of slot s, for s = 1 to 12. A flag is 1 only for a slot that carries enabled content. Tag bits 5 down to 2 are always 0.
- R6: Tag bits 1:0 equal `req_codec_id` of the accepted request. A frame sent without an accepted request carries 00 there.
- R7: Slot 1 carries `req_cmd_addr` when `req_addr_en` is 1, and slot 2 carries `req_cmd_data` when `req_data_en` is 1. Otherwise each of these slots is 0.
- R8: The left and right samples (when enabled) go in slots 3 and 4 for codec ID 00 or 01, slots 7 and 8 for ID 10, and slots 6 and 9 for ID 11.
- R9: Every slot that holds no enabled content is sent as all zeros, including slots 10 to 12 and a disabled sample's slot.
- R10: A request is captured only at the handshake edge. Values presented while `req_ready` is low have no effect on the frame. With no request at the handshake edge the whole next frame (tag and slots) is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; every register in the block uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Block takes a request on this edge (last bit of frame) |
| req_codec_id | input | 2 | Target codec identifier |
| req_addr_en | input | 1 | Send command address in slot 1 |
| req_data_en | input | 1 | Send command data in slot 2 |
| req_left_en | input | 1 | Send left sample |
| req_right_en | input | 1 | Send right sample |
| req_cmd_addr | input | SLOT_W | Command address slot payload |
| req_cmd_data | input | SLOT_W | Command data slot payload |
| req_pcm_left | input | SLOT_W | Left playback sample |
| req_pcm_right | input | SLOT_W | Right playback sample |
| ac_sync | output | 1 | Frame marker, high during the tag phase |
| ac_sdout | output | 1 | Serial frame data, MSB first |

## Verification
The bench builds the block with its default slot width of 20 bits. At that width the frame length, the tag layout and the slot boundaries match the link exactly, so every captured 256-bit frame can be compared slot by slot against a frame built independently in the bench. All four codec identifiers are covered, along with partial enable sets, a request with no enables, a frame with no request, and a request whose fields change before the handshake. These cases reach every slot-placement variant and the zero-fill and zero-tag corners. Full-scale and alternating samples expose bit-order and slot-boundary errors.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int unsigned TAG_W      = 16;
  localparam int unsigned DATA_SLOTS = 12;

  typedef struct packed {
    logic [1:0] codec_id;
    logic       addr_en;
    logic       data_en;
    logic       left_en;
    logic       right_en;
  } req_ctl_t;

  function automatic int unsigned left_slot(input logic [1:0] id);
    case (id)
      2'b10:   return 7;
      2'b11:   return 6;
      default: return 3;
    endcase
  endfunction

  function automatic int unsigned right_slot(input logic [1:0] id);
    case (id)
      2'b10:   return 8;
      2'b11:   return 9;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned SYNC_BITS  = 16
) (
  input  logic bit_clk,
  input  logic rst_n,
  output logic frame_last,
  output logic sync_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign frame_last = (cnt_q == LAST);
  assign sync_o     = (cnt_q < CW'(SYNC_BITS));
endmodule

// File: rtl/aclink_slot_map.sv
module aclink_slot_map
  import aclink_tx_pkg::*;
#(
  parameter int unsigned SLOT_W = 20
) (
  input  req_ctl_t                      ctl,
  input  logic [SLOT_W-1:0]             cmd_addr,
  input  logic [SLOT_W-1:0]             cmd_data,
  input  logic [SLOT_W-1:0]             pcm_left,
  input  logic [SLOT_W-1:0]             pcm_right,
  output logic [DATA_SLOTS*SLOT_W-1:0]  payload,
  output logic [DATA_SLOTS:1]           slot_vld
);
  int unsigned l_idx, r_idx;
  assign l_idx = left_slot(ctl.codec_id);
  assign r_idx = right_slot(ctl.codec_id);

  for (genvar s = 1; s <= DATA_SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] word;
    logic              used;
    always_comb begin
      word = '0;
      used = 1'b0;
      if (s == 1 && ctl.addr_en) begin
        word = cmd_addr; used = 1'b1;
      end else if (s == 2 && ctl.data_en) begin
        word = cmd_data; used = 1'b1;
      end else if (s == l_idx && ctl.left_en) begin
        word = pcm_left; used = 1'b1;
      end else if (s == r_idx && ctl.right_en) begin
        word = pcm_right; used = 1'b1;
      end
    end
    assign payload[(DATA_SLOTS-s)*SLOT_W +: SLOT_W] = word;
    assign slot_vld[s] = used;
  end
endmodule

// File: rtl/aclink_tag_build.sv
module aclink_tag_build
  import aclink_tx_pkg::*;
(
  input  logic [DATA_SLOTS:1] slot_vld,
  input  logic [1:0]          codec_id,
  output logic [TAG_W-1:0]    tag
);
  always_comb begin
    tag = '0;
    tag[TAG_W-1] = |slot_vld;
    for (int s = 1; s <= 12; s++) begin
      tag[TAG_W-1-s] = slot_vld[s];
    end
    tag[5:2] = 4'b0000;
    tag[1:0] = codec_id;
  end
endmodule

// File: rtl/aclink_frame_shift.sv
module aclink_frame_shift #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  bit_clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic                  sdata_o
);
  logic [FRAME_BITS-1:0] frame_q;
  logic                  sdata_q;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      sdata_q <= 1'b0;
    end else begin
      sdata_q <= frame_q[FRAME_BITS-1];
      if (load) frame_q <= frame_in;
      else      frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx
  import aclink_tx_pkg::*;
#(
  parameter int unsigned SLOT_W = 20
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_codec_id,
  input  logic              req_addr_en,
  input  logic              req_data_en,
  input  logic              req_left_en,
  input  logic              req_right_en,
  input  logic [SLOT_W-1:0] req_cmd_addr,
  input  logic [SLOT_W-1:0] req_cmd_data,
  input  logic [SLOT_W-1:0] req_pcm_left,
  input  logic [SLOT_W-1:0] req_pcm_right,
  output logic              ac_sync,
  output logic              ac_sdout
);
  localparam int unsigned PAY_W      = DATA_SLOTS * SLOT_W;
  localparam int unsigned FRAME_BITS = TAG_W + PAY_W;

  logic                  frame_last;
  req_ctl_t              ctl;
  logic [PAY_W-1:0]      payload;
  logic [DATA_SLOTS:1]   slot_vld;
  logic [TAG_W-1:0]      tag;
  logic [FRAME_BITS-1:0] next_frame;
  logic                  take;

  aclink_bit_timer #(.FRAME_BITS(FRAME_BITS), .SYNC_BITS(TAG_W)) u_timer (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .frame_last (frame_last),
    .sync_o     (ac_sync)
  );

  assign req_ready = frame_last;
  assign take      = frame_last & req_valid;

  always_comb begin
    ctl.codec_id = req_codec_id;
    ctl.addr_en  = req_addr_en;
    ctl.data_en  = req_data_en;
    ctl.left_en  = req_left_en;
    ctl.right_en = req_right_en;
  end

  aclink_slot_map #(.SLOT_W(SLOT_W)) u_map (
    .ctl       (ctl),
    .cmd_addr  (req_cmd_addr),
    .cmd_data  (req_cmd_data),
    .pcm_left  (req_pcm_left),
    .pcm_right (req_pcm_right),
    .payload   (payload),
    .slot_vld  (slot_vld)
  );

  aclink_tag_build u_tag (
    .slot_vld (slot_vld),
    .codec_id (req_codec_id),
    .tag      (tag)
  );

  assign next_frame = take ? {tag, payload} : '0;

  aclink_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .load     (frame_last),
    .frame_in (next_frame),
    .sdata_o  (ac_sdout)
  );
endmodule

// File: rtl/aclink_frame_tx_chk.sv
module aclink_frame_tx_chk
  import aclink_tx_pkg::*;
(
  input logic bit_clk,
  input logic rst_n,
  input logic req_ready,
  input logic ac_sync,
  input logic ac_sdout
);
  logic [5:0] hi_cnt;
  logic [9:0] pos;
  logic       sync_d;
  logic       armed;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      pos    <= '0;
      sync_d <= 1'b0;
      armed  <= 1'b0;
    end else begin
      sync_d <= ac_sync;
      hi_cnt <= ac_sync ? hi_cnt + 1'b1 : '0;
      if (ac_sync && !sync_d) begin
        pos   <= 10'd1;
        armed <= 1'b1;
      end else if (pos != 10'h3FF) begin
        pos <= pos + 1'b1;
      end
    end
  end

  assert_ready_pulse_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_sync_after_ready_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(ac_sync) |-> $past(req_ready));

  assert_sync_width_max_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    ac_sync |-> (hi_cnt < 6'(TAG_W)));

  assert_sync_width_full_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(ac_sync) |-> (hi_cnt == 6'(TAG_W)));

  assert_tag_zero_bits_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (armed && pos >= 10'd11 && pos <= 10'd14) |-> !ac_sdout);
endmodule

bind aclink_frame_tx aclink_frame_tx_chk u_chk (
  .bit_clk   (bit_clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ac_sync   (ac_sync),
  .ac_sdout  (ac_sdout)
);

// File: tb/aclink_frame_tx_bench.sv
module aclink_frame_tx_bench;
  localparam int SW = 20;
  localparam int FB = 256;

  logic          bit_clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_codec_id;
  logic          req_addr_en, req_data_en, req_left_en, req_right_en;
  logic [SW-1:0] req_cmd_addr, req_cmd_data, req_pcm_left, req_pcm_right;
  logic          ac_sync, ac_sdout;

  int checks = 0;
  int failures = 0;
  logic [FB-1:0] got;
  int sync_bad;

  always #5 bit_clk = ~bit_clk;

  aclink_frame_tx #(.SLOT_W(SW)) u_aclink_frame_tx (
    .bit_clk(bit_clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_codec_id(req_codec_id),
    .req_addr_en(req_addr_en), .req_data_en(req_data_en),
    .req_left_en(req_left_en), .req_right_en(req_right_en),
    .req_cmd_addr(req_cmd_addr), .req_cmd_data(req_cmd_data),
    .req_pcm_left(req_pcm_left), .req_pcm_right(req_pcm_right),
    .ac_sync(ac_sync), .ac_sdout(ac_sdout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] build_exp(input logic [1:0] id, input logic ae, de, le, re,
      input logic [SW-1:0] a, d, l, r);
    logic [SW-1:0] sl [1:12];
    logic [15:0]   tg;
    int ls, rs;
    logic [FB-1:0] f;
    for (int s = 1; s <= 12; s++) sl[s] = '0;
    ls = (id == 2'b10) ? 7 : (id == 2'b11) ? 6 : 3;
    rs = (id == 2'b10) ? 8 : (id == 2'b11) ? 9 : 4;
    if (ae) sl[1] = a;
    if (de) sl[2] = d;
    if (le) sl[ls] = l;
    if (re) sl[rs] = r;
    tg = '0;
    tg[15] = ae | de | le | re;
    tg[14] = ae; tg[13] = de;
    if (le) tg[15-ls] = 1'b1;
    if (re) tg[15-rs] = 1'b1;
    tg[1:0] = id;
    f = '0;
    f[FB-1 -: 16] = tg;
    for (int s = 1; s <= 12; s++) f[(12-s)*SW +: SW] = sl[s];
    return f;
  endfunction

  task automatic set_req(input logic v, input logic [1:0] id, input logic ae, de, le, re,
      input logic [SW-1:0] a, d, l, r);
    req_valid = v; req_codec_id = id;
    req_addr_en = ae; req_data_en = de; req_left_en = le; req_right_en = re;
    req_cmd_addr = a; req_cmd_data = d; req_pcm_left = l; req_pcm_right = r;
  endtask

  // waits for the handshake, then captures the following frame
  task automatic grab_frame();
    do @(negedge bit_clk); while (!req_ready);
    @(negedge bit_clk);
    chk(ac_sync == 1'b1, "R2 sync at frame start", 32'(ac_sync), 32'h1);
    req_valid = 1'b0;
    sync_bad = 0;
    for (int i = 0; i < FB; i++) begin
      @(negedge bit_clk);
      got[FB-1-i] = ac_sdout;
      if (ac_sync != (((i + 1) % FB) < 16)) sync_bad++;
    end
    chk(sync_bad == 0, "R2 sync high 16 of 256", 32'(sync_bad), 32'h0);
  endtask

  task automatic cmp_frame(input string name, input logic [FB-1:0] exp, input logic [1:0] id);
    int ls, rs;
    ls = (id == 2'b10) ? 7 : (id == 2'b11) ? 6 : 3;
    rs = (id == 2'b10) ? 8 : (id == 2'b11) ? 9 : 4;
    chk(got[FB-1] == exp[FB-1], {name, " R4 valid-frame bit"}, 32'(got[FB-1]), 32'(exp[FB-1]));
    chk(got[FB-2 -: 12] == exp[FB-2 -: 12], {name, " R5 slot flags"}, 32'(got[FB-2 -: 12]), 32'(exp[FB-2 -: 12]));
    chk(got[241:240] == exp[241:240], {name, " R6 codec id"}, 32'(got[241:240]), 32'(exp[241:240]));
    chk(got[FB-1 -: 16] == exp[FB-1 -: 16], {name, " R3 whole tag"}, 32'(got[FB-1 -: 16]), 32'(exp[FB-1 -: 16]));
    for (int s = 1; s <= 12; s++) begin
      logic [SW-1:0] g, e;
      string rq;
      g = got[(12-s)*SW +: SW];
      e = exp[(12-s)*SW +: SW];
      rq = (s <= 2) ? "R7" : ((s == ls || s == rs) ? "R8" : "R9");
      chk(g == e, $sformatf("%s %s slot %0d", name, rq, s), 32'(g), 32'(e));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_req(1'b0, 2'b00, 0, 0, 0, 0, '0, '0, '0, '0);
    repeat (3) @(negedge bit_clk);
    chk(ac_sync == 1'b0, "R1 reset sync", 32'(ac_sync), 32'h0);
    chk(ac_sdout == 1'b0, "R1 reset sdout", 32'(ac_sdout), 32'h0);
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;
  endtask

  task automatic t_frame(input string name, input logic [1:0] id, input logic ae, de, le, re,
      input logic [SW-1:0] a, d, l, r);
    set_req(1'b1, id, ae, de, le, re, a, d, l, r);
    grab_frame();
    cmp_frame(name, build_exp(id, ae, de, le, re, a, d, l, r), id);
  endtask

  task automatic t_idle();
    set_req(1'b0, 2'b11, 1, 1, 1, 1, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF);
    grab_frame();
    chk(got == '0, "R10 idle frame all zero", 32'(got[FB-1 -: 32]), 32'h0);
  endtask

  task automatic t_ready_period();
    int gap;
    do @(negedge bit_clk); while (!req_ready);
    gap = 0;
    do begin @(negedge bit_clk); gap++; end while (!req_ready);
    chk(gap == FB, "R1 frame length", 32'(gap), 32'(FB));
  endtask

  task automatic t_late_change();
    do @(negedge bit_clk); while (req_ready);
    set_req(1'b1, 2'b11, 1, 1, 1, 1, 20'h11111, 20'h22222, 20'h33333, 20'h44444);
    repeat (40) @(negedge bit_clk);
    set_req(1'b1, 2'b10, 0, 1, 1, 0, 20'hABCDE, 20'h5A5A5, 20'hF0F0F, 20'h0F0F0);
    grab_frame();
    cmp_frame("late R10", build_exp(2'b10, 0, 1, 1, 0, 20'hABCDE, 20'h5A5A5, 20'hF0F0F, 20'h0F0F0), 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge bit_clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_ready_period();
    t_frame("id00 full", 2'b00, 1, 1, 1, 1, 20'h80001, 20'h7FFFE, 20'hFFFFF, 20'hAAAAA);
    t_frame("id01 full", 2'b01, 1, 1, 1, 1, 20'h12345, 20'h6789A, 20'h55555, 20'hC3C3C);
    t_frame("id10 pcm", 2'b10, 0, 0, 1, 1, 20'h0, 20'h0, 20'hFFFFF, 20'h80000);
    t_frame("id11 pcm", 2'b11, 1, 0, 1, 1, 20'h00F00, 20'h0, 20'h00001, 20'hFFFFF);
    t_frame("id11 left only", 2'b11, 0, 0, 1, 0, 20'hFFFFF, 20'hFFFFF, 20'h9ABCD, 20'hFFFFF);
    t_frame("id00 cmd only", 2'b00, 1, 1, 0, 0, 20'hFFFFF, 20'h00001, 20'hFFFFF, 20'hFFFFF);
    t_frame("id10 none", 2'b10, 0, 0, 0, 0, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF);
    t_idle();
    t_late_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule